// File: doc/BRIEF.md
# Hot-Plug Slot Register Controller

This block keeps the slot control and slot status registers of a hot-plug capable downstream port. Software reaches both registers over a simple write bus with a register select, two byte enables and 16-bit write data; the current value of each register is driven out continuously for readback. Any write that touches the control register counts as one command. It takes effect at the next clock edge, and command completed is set at that same edge. The command can toggle the electromechanical interlock. It can also detach the card in the slot when it turns power off with the power indicator set to off.

A presence-sense side delivers insert and remove requests and an attention-button press strobe. While the interlock is engaged, a normal insert or remove is refused with a one-cycle busy pulse. A cold-plug insert at boot is always taken and sets presence without raising a change event. One hot-plug interrupt line combines the enabled change bits, gated by the master hot-plug enable. The `boot_present_i` level gives the presence state that reset loads, and the power reset defaults follow from it.

Top module: `hp_slot_ctrl`

## Requirements
- R1: During reset the control register reads with bits 0, 3, 4, 5 and 11 clear and the attention indicator field (bits 7:6) at 11 (off). When `boot_present_i` is 1, power control (bit 10) is 0 and the power indicator (bits 9:8) is 01 (on), giving 0x01C0. When it is 0, bit 10 is 1 and bits 9:8 are 11, giving 0x07C0.
- R2: During reset the status change bits 0, 3 and 4 and the interlock status (bit 7) are 0, and presence state (bit 6) equals `boot_present_i`.
- R3: A control command with bit 11 written 1 on enabled byte lane 1 inverts status bit 7. Control bit 11 always reads 0.
- R4: A write to the control register (`reg_addr_i`=0) with `reg_be_i`=00 is not a command and changes nothing. Otherwise only bits in enabled lanes are updated (lane 0 = bits 7:0, lane 1 = bits 15:8), and only bits 0 and 3..10 are writable.
- R5: A command with lane 1 enabled, bit 10 written 1 and bits 9:8 written 11, issued while status bit 6 is 1, gives a one-cycle `detach_o` pulse in the cycle after the write. In that same cycle status bit 6 reads 0 and bit 3 reads 1. Any other write produces no pulse.
- R6: Every command sets status bit 4 at the clock edge that applies it.
- R7: A status write (`reg_addr_i`=1) with lane 0 enabled clears each of bits 0, 3 and 4 where the data bit is 1. Data bits of 0 leave the bit unchanged, and a set event in the same cycle wins over the clear.
- R8: A non-cold insert or remove request while status bit 7 is 1 changes no register and gives `busy_o` high for the cycle after the request.
- R9: An accepted insert sets status bit 6 and sets bit 3. An accepted remove clears bit 6 and sets bit 3.
- R10: An insert with `plug_cold_i`=1 is always accepted, even when locked. It sets bit 6 and leaves bit 3 unchanged.
- R11: `irq_o` is control bit 5 AND the OR of (status0 & control0), (status3 & control3) and (status4 & control4).
- R12: An `attn_press_i` strobe sets status bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| boot_present_i | input | 1 | Slot occupied at reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 1 | 0 = control, 1 = status |
| reg_be_i | input | 2 | Byte enables |
| reg_wdata_i | input | 16 | Write data |
| plug_req_i | input | 1 | Insert/remove request strobe |
| plug_insert_i | input | 1 | 1 = insert, 0 = remove |
| plug_cold_i | input | 1 | Request is a boot-time cold insert |
| attn_press_i | input | 1 | Attention button pressed strobe |
| ctrl_o | output | 16 | Control register readback |
| status_o | output | 16 | Status register readback |
| detach_o | output | 1 | One-cycle card detach pulse |
| busy_o | output | 1 | One-cycle refusal of a plug request |
| irq_o | output | 1 | Hot-plug interrupt request |

## Verification
The bench targets the edges of the detach rule: power off with a blinking indicator, the same data with lane 1 disabled, and a repeat on an empty slot. A design that checked too few written fields would pulse `detach_o` and clear presence by mistake. It also targets commands with no byte enabled and lane-gated status clears. A design that treated every write as a command would set command completed or erase pending changes. The lock cases check that a locked slot refuses hot requests but still accepts a cold insert. A design that missed this would alter presence or never report busy. Finally, the bench resets once with the slot full and once with it empty. A design with a fixed power default would fail one of the two.

// File: rtl/hp_slot_pkg.sv
package hp_slot_pkg;
  localparam int unsigned REG_W = 16;
  localparam int unsigned BE_W  = REG_W / 8;

  // control bit positions
  localparam int unsigned C_ABP_EN   = 0;
  localparam int unsigned C_PDC_EN   = 3;
  localparam int unsigned C_CC_EN    = 4;
  localparam int unsigned C_HP_EN    = 5;
  localparam int unsigned C_AI_LO    = 6;
  localparam int unsigned C_PI_LO    = 8;
  localparam int unsigned C_PWR_OFF  = 10;
  localparam int unsigned C_LOCK_TGL = 11;

  // status bit positions
  localparam int unsigned S_ABP  = 0;
  localparam int unsigned S_PDC  = 3;
  localparam int unsigned S_CC   = 4;
  localparam int unsigned S_PDS  = 6;
  localparam int unsigned S_LOCK = 7;

  typedef enum logic [1:0] {
    IND_RSVD  = 2'b00,
    IND_ON    = 2'b01,
    IND_BLINK = 2'b10,
    IND_OFF   = 2'b11
  } ind_e;

  localparam logic [REG_W-1:0] CTRL_RW_MASK = 16'h07F9;
endpackage

// File: rtl/hp_slot_lane_mask.sv
module hp_slot_lane_mask #(
  parameter int unsigned REG_W = 16,
  localparam int unsigned BE_W = REG_W / 8
) (
  input  logic [BE_W-1:0]  be_i,
  output logic [REG_W-1:0] mask_o
);
  for (genvar i = 0; i < BE_W; i++) begin : g_lane
    assign mask_o[i*8 +: 8] = {8{be_i[i]}};
  end
endmodule

// File: rtl/hp_slot_ctrl_reg.sv
module hp_slot_ctrl_reg
  import hp_slot_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             boot_present_i,
  input  logic             cmd_i,
  input  logic [REG_W-1:0] lane_mask_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic             pds_i,
  output logic [REG_W-1:0] ctrl_o,
  output logic             lock_tgl_o,
  output logic             detach_o
);
  logic [REG_W-1:0] ctrl_q, rst_val, wr_mask;

  always_comb begin
    rst_val = '0;
    rst_val[C_AI_LO +: 2] = IND_OFF;
    if (boot_present_i) begin
      rst_val[C_PI_LO +: 2] = IND_ON;
    end else begin
      rst_val[C_PI_LO +: 2] = IND_OFF;
      rst_val[C_PWR_OFF]    = 1'b1;
    end
  end

  assign wr_mask = lane_mask_i & CTRL_RW_MASK;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    ctrl_q <= rst_val;
    else if (cmd_i) ctrl_q <= (ctrl_q & ~wr_mask) | (wdata_i & wr_mask);
  end

  // interlock control is an action, never stored
  assign lock_tgl_o = cmd_i & lane_mask_i[C_LOCK_TGL] & wdata_i[C_LOCK_TGL];

  // power off + indicator off on an occupied slot, judged on written data
  assign detach_o = cmd_i & pds_i
                  & lane_mask_i[C_PWR_OFF] & wdata_i[C_PWR_OFF]
                  & (wdata_i[C_PI_LO +: 2] == IND_OFF);

  assign ctrl_o = ctrl_q;
endmodule

// File: rtl/hp_slot_stat_reg.sv
module hp_slot_stat_reg
  import hp_slot_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             boot_present_i,
  input  logic             clr_abp_i,
  input  logic             clr_pdc_i,
  input  logic             clr_cc_i,
  input  logic             cmd_i,
  input  logic             lock_tgl_i,
  input  logic             detach_i,
  input  logic             plug_req_i,
  input  logic             plug_insert_i,
  input  logic             plug_cold_i,
  input  logic             attn_press_i,
  output logic [REG_W-1:0] status_o,
  output logic             detach_o,
  output logic             busy_o
);
  logic abp_q, pdc_q, cc_q, pds_q, lock_q;
  logic cold_ins, hot_req, hot_acc, refuse;
  logic pds_n;

  assign cold_ins = plug_req_i & plug_insert_i & plug_cold_i;
  assign hot_req  = plug_req_i & ~cold_ins;
  assign hot_acc  = hot_req & ~lock_q;
  assign refuse   = hot_req &  lock_q;

  always_comb begin
    pds_n = pds_q;
    if (detach_i)            pds_n = 1'b0;
    if (hot_acc | cold_ins)  pds_n = plug_insert_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      abp_q    <= 1'b0;
      pdc_q    <= 1'b0;
      cc_q     <= 1'b0;
      lock_q   <= 1'b0;
      pds_q    <= boot_present_i;
      detach_o <= 1'b0;
      busy_o   <= 1'b0;
    end else begin
      abp_q    <= (abp_q & ~clr_abp_i) | attn_press_i;
      pdc_q    <= (pdc_q & ~clr_pdc_i) | detach_i | hot_acc;
      cc_q     <= (cc_q  & ~clr_cc_i)  | cmd_i;
      lock_q   <= lock_q ^ lock_tgl_i;
      pds_q    <= pds_n;
      detach_o <= detach_i;
      busy_o   <= refuse;
    end
  end

  always_comb begin
    status_o         = '0;
    status_o[S_ABP]  = abp_q;
    status_o[S_PDC]  = pdc_q;
    status_o[S_CC]   = cc_q;
    status_o[S_PDS]  = pds_q;
    status_o[S_LOCK] = lock_q;
  end
endmodule

// File: rtl/hp_slot_irq.sv
module hp_slot_irq (
  input  logic hp_en_i,
  input  logic abp_en_i,
  input  logic pdc_en_i,
  input  logic cc_en_i,
  input  logic abp_i,
  input  logic pdc_i,
  input  logic cc_i,
  output logic irq_o
);
  assign irq_o = hp_en_i & ((abp_i & abp_en_i) | (pdc_i & pdc_en_i) | (cc_i & cc_en_i));
endmodule

// File: rtl/hp_slot_ctrl.sv
module hp_slot_ctrl
  import hp_slot_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             boot_present_i,
  input  logic             reg_wr_i,
  input  logic             reg_addr_i,
  input  logic [BE_W-1:0]  reg_be_i,
  input  logic [REG_W-1:0] reg_wdata_i,
  input  logic             plug_req_i,
  input  logic             plug_insert_i,
  input  logic             plug_cold_i,
  input  logic             attn_press_i,
  output logic [REG_W-1:0] ctrl_o,
  output logic [REG_W-1:0] status_o,
  output logic             detach_o,
  output logic             busy_o,
  output logic             irq_o
);
  logic [REG_W-1:0] lane_mask, w1c;
  logic cmd, stat_wr, lock_tgl, detach_req;

  hp_slot_lane_mask #(.REG_W(REG_W)) u_lane (
    .be_i  (reg_be_i),
    .mask_o(lane_mask)
  );

  assign cmd     = reg_wr_i & ~reg_addr_i & (|reg_be_i);
  assign stat_wr = reg_wr_i &  reg_addr_i;
  assign w1c     = {REG_W{stat_wr}} & lane_mask & reg_wdata_i;

  hp_slot_ctrl_reg u_ctrl (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .boot_present_i(boot_present_i),
    .cmd_i         (cmd),
    .lane_mask_i   (lane_mask),
    .wdata_i       (reg_wdata_i),
    .pds_i         (status_o[S_PDS]),
    .ctrl_o        (ctrl_o),
    .lock_tgl_o    (lock_tgl),
    .detach_o      (detach_req)
  );

  hp_slot_stat_reg u_stat (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .boot_present_i(boot_present_i),
    .clr_abp_i     (w1c[S_ABP]),
    .clr_pdc_i     (w1c[S_PDC]),
    .clr_cc_i      (w1c[S_CC]),
    .cmd_i         (cmd),
    .lock_tgl_i    (lock_tgl),
    .detach_i      (detach_req),
    .plug_req_i    (plug_req_i),
    .plug_insert_i (plug_insert_i),
    .plug_cold_i   (plug_cold_i),
    .attn_press_i  (attn_press_i),
    .status_o      (status_o),
    .detach_o      (detach_o),
    .busy_o        (busy_o)
  );

  hp_slot_irq u_irq (
    .hp_en_i (ctrl_o[C_HP_EN]),
    .abp_en_i(ctrl_o[C_ABP_EN]),
    .pdc_en_i(ctrl_o[C_PDC_EN]),
    .cc_en_i (ctrl_o[C_CC_EN]),
    .abp_i   (status_o[S_ABP]),
    .pdc_i   (status_o[S_PDC]),
    .cc_i    (status_o[S_CC]),
    .irq_o   (irq_o)
  );
endmodule

// File: rtl/hp_slot_ctrl_chk.sv
module hp_slot_ctrl_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        reg_wr_i,
  input logic        reg_addr_i,
  input logic [1:0]  reg_be_i,
  input logic [15:0] ctrl_o,
  input logic [15:0] status_o,
  input logic        detach_o,
  input logic        busy_o,
  input logic        irq_o
);
  AST_LOCK_CTRL_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_o[11]); // R3

  AST_NO_BE_NO_CMD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_i && !reg_addr_i && reg_be_i == 2'b00 && !status_o[4]) |=> !status_o[4]); // R4

  AST_DETACH_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    detach_o |=> !detach_o); // R5

  AST_DETACH_STATUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    detach_o |-> (!status_o[6] && status_o[3])); // R5

  AST_CMD_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_i && !reg_addr_i && reg_be_i != 2'b00) |=> status_o[4]); // R6

  AST_BUSY_LOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> $past(status_o[7])); // R8

  AST_IRQ_MASTER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ctrl_o[5]); // R11
endmodule

bind hp_slot_ctrl hp_slot_ctrl_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .reg_wr_i  (reg_wr_i),
  .reg_addr_i(reg_addr_i),
  .reg_be_i  (reg_be_i),
  .ctrl_o    (ctrl_o),
  .status_o  (status_o),
  .detach_o  (detach_o),
  .busy_o    (busy_o),
  .irq_o     (irq_o)
);

// File: tb/hp_slot_ctrl_tb.sv
`timescale 1ns/1ps
module hp_slot_ctrl_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        boot_present_i = 1'b1;
  logic        reg_wr_i = 1'b0;
  logic        reg_addr_i = 1'b0;
  logic [1:0]  reg_be_i = '0;
  logic [15:0] reg_wdata_i = '0;
  logic        plug_req_i = 1'b0;
  logic        plug_insert_i = 1'b0;
  logic        plug_cold_i = 1'b0;
  logic        attn_press_i = 1'b0;
  logic [15:0] ctrl_o, status_o;
  logic        detach_o, busy_o, irq_o;

  hp_slot_ctrl u_dut (.*);

  always #2.5 clk_i = ~clk_i;

  typedef struct {
    int          due;
    logic [15:0] ctrl;
    logic [15:0] stat;
    logic        det;
    logic        busy;
    logic        irq;
    string       tag;
  } exp_t;

  exp_t        sb[$];
  int          cyc = 0;
  int          vectors = 0;
  int          miscompares = 0;
  logic [15:0] mc, ms;

  always @(posedge clk_i) cyc <= cyc + 1;

  function automatic logic model_irq(logic [15:0] c, logic [15:0] s);
    return c[5] & ((c[0] & s[0]) | (c[3] & s[3]) | (c[4] & s[4]));
  endfunction

  task automatic compare(exp_t e);
    vectors++;
    if (ctrl_o !== e.ctrl || status_o !== e.stat || detach_o !== e.det ||
        busy_o !== e.busy || irq_o !== e.irq) begin
      miscompares++;
      $display("FAIL %s: got ctrl=%h stat=%h det=%b busy=%b irq=%b exp ctrl=%h stat=%h det=%b busy=%b irq=%b",
               e.tag, ctrl_o, status_o, detach_o, busy_o, irq_o,
               e.ctrl, e.stat, e.det, e.busy, e.irq);
    end
  endtask

  // monitor
  always @(negedge clk_i) begin
    while (sb.size() > 0 && sb[0].due <= cyc) compare(sb.pop_front());
  end

  // driver: one bus/plug cycle, expected result pushed to scoreboard
  task automatic op(input logic wr, input logic addr, input logic [1:0] be,
                    input logic [15:0] wd, input logic preq, input logic pins,
                    input logic pcold, input logic attn, input string tag);
    logic [15:0] lm, nmc, nms, rw;
    logic cmd, det, tgl, cold_ins, hot, bsy;
    exp_t e;
    @(negedge clk_i);
    reg_wr_i = wr; reg_addr_i = addr; reg_be_i = be; reg_wdata_i = wd;
    plug_req_i = preq; plug_insert_i = pins; plug_cold_i = pcold; attn_press_i = attn;
    lm       = {{8{be[1]}}, {8{be[0]}}};
    rw       = 16'h07F9;
    cmd      = wr && !addr && (be != 2'b00);
    det      = cmd && ms[6] && lm[10] && wd[10] && wd[9:8] == 2'b11;
    tgl      = cmd && lm[11] && wd[11];
    cold_ins = preq && pins && pcold;
    hot      = preq && !cold_ins && !ms[7];
    bsy      = preq && !cold_ins && ms[7];
    nms = ms;
    if (wr && addr) nms = nms & ~(wd & lm & 16'h0019);
    if (attn) nms[0] = 1'b1;
    if (cmd)  nms[4] = 1'b1;
    if (det)  begin nms[6] = 1'b0; nms[3] = 1'b1; end
    if (hot)  begin nms[6] = pins; nms[3] = 1'b1; end
    if (cold_ins) nms[6] = 1'b1;
    if (tgl)  nms[7] = ~ms[7];
    nmc = cmd ? ((mc & ~(lm & rw)) | (wd & lm & rw)) : mc;
    mc = nmc; ms = nms;
    e.due = cyc + 1; e.ctrl = mc; e.stat = ms; e.det = det; e.busy = bsy;
    e.irq = model_irq(mc, ms); e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic idle(input string tag);
    op(1'b0, 1'b0, 2'b00, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b0, tag);
  endtask

  task automatic do_reset(input logic present);
    exp_t e;
    @(negedge clk_i);
    rst_ni = 1'b0; boot_present_i = present;
    reg_wr_i = 1'b0; plug_req_i = 1'b0; attn_press_i = 1'b0;
    sb.delete();
    @(negedge clk_i);
    mc = present ? 16'h01C0 : 16'h07C0;
    ms = present ? 16'h0040 : 16'h0000;
    e.due = 0; e.ctrl = mc; e.stat = ms; e.det = 1'b0; e.busy = 1'b0;
    e.irq = 1'b0; e.tag = "R1 R2 reset";
    compare(e);
    rst_ni = 1'b1;
  endtask

  initial begin
    do_reset(1'b1);
    idle("R1 after reset");
    op(1, 0, 2'b00, 16'hFFFF, 0, 0, 0, 0, "R4 no byte enabled");
    op(1, 0, 2'b01, 16'h0039, 0, 0, 0, 0, "R6 R11 enables written");
    op(1, 1, 2'b10, 16'h1010, 0, 0, 0, 0, "R7 clear on disabled lane");
    op(1, 1, 2'b01, 16'h0010, 0, 0, 0, 0, "R7 clear cc");
    op(1, 0, 2'b11, 16'h0939, 0, 0, 0, 0, "R3 lock toggle on");
    op(0, 0, 2'b00, 16'h0000, 1, 0, 0, 0, "R8 remove while locked");
    op(0, 0, 2'b00, 16'h0000, 1, 1, 0, 0, "R8 insert while locked");
    op(0, 0, 2'b00, 16'h0000, 1, 1, 1, 0, "R10 cold insert while locked");
    op(1, 0, 2'b10, 16'h0800, 0, 0, 0, 0, "R3 lock toggle off");
    op(1, 1, 2'b01, 16'h0019, 0, 0, 0, 1, "R7 R12 attn wins over clear");
    op(1, 1, 2'b01, 16'h0008, 0, 0, 0, 0, "R7 clear only pdc");
    op(1, 1, 2'b01, 16'h0011, 0, 0, 0, 0, "R7 clear abp cc");
    op(1, 0, 2'b11, 16'h0639, 0, 0, 0, 0, "R5 power off indicator blink");
    op(1, 0, 2'b01, 16'h0739, 0, 0, 0, 0, "R4 R5 lane1 disabled");
    op(1, 0, 2'b11, 16'h0739, 0, 0, 0, 0, "R5 detach");
    idle("R5 pulse ends");
    op(1, 0, 2'b11, 16'h0739, 0, 0, 0, 0, "R5 empty slot no detach");
    op(0, 0, 2'b00, 16'h0000, 1, 1, 0, 0, "R9 hot insert");
    op(1, 1, 2'b01, 16'h0018, 0, 0, 0, 0, "R7 clear pdc cc");
    op(0, 0, 2'b00, 16'h0000, 1, 0, 0, 0, "R9 hot remove");
    op(1, 1, 2'b01, 16'h0018, 0, 0, 0, 0, "R7 clear pdc cc again");
    op(0, 0, 2'b00, 16'h0000, 1, 1, 1, 0, "R10 cold insert empty");
    op(1, 0, 2'b01, 16'h0019, 0, 0, 0, 0, "R11 hp enable off");
    op(0, 0, 2'b00, 16'h0000, 0, 0, 0, 1, "R11 R12 press masked");
    idle("R11 settle");
    do_reset(1'b0);
    idle("R1 R2 empty boot");
    op(1, 0, 2'b10, 16'h0100, 0, 0, 0, 0, "R4 lane1 only");
    repeat (3) idle("tail");
    repeat (2) @(negedge clk_i);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    miscompares++;
    $display("FAIL watchdog: got hang expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule